// File: doc/BRIEF.md
# Asynchronous DRAM Controller with Background Refresh

This block drives a classic asynchronous DRAM that has a multiplexed row/column address bus and active-low row strobe, column strobe and write-enable pins. A host hands it single-word reads and writes over a valid/ready handshake. The controller opens a row, keeps it open across any number of column accesses to that row, and closes it when the host moves to another row. It also closes the row when the longest allowed row-strobe low time is close, or when a refresh is due.

Refresh uses the DRAM's own row counter. The column strobe goes low before the row strobe. A timer derived from the clock frequency asks for a short burst of row-strobe pulses at a fixed rate, and the column strobe stays low for the whole burst. A pending refresh is served at the next access boundary, ahead of any host request. All DRAM timing limits are parameters counted in clock cycles. Read data comes back in request order with a one-cycle valid pulse.

Top module: `dram_ctl`

## Requirements
- R1: Out of reset, and whenever no row is open and no refresh runs, the row strobe, column strobe and write-enable outputs are all high, the data output enable is low, and `req_ready` is high.
- R2: A row is opened by putting the row address (request address bits above the column field) on `dram_addr` one cycle before the row strobe falls and holding it there. The column strobe then falls no earlier than `T_RCD` cycles after the row strobe fell.
- R3: A read puts the column address (the low `COL_W` request bits) on `dram_addr`, keeps write-enable high and drops the column strobe for `T_CAS` cycles. The DRAM data sampled in the last of those cycles appears on `rd_data` with `rd_valid` high for exactly one cycle.
- R4: A write drives write-enable low at least one cycle before the column strobe falls. It drives `dram_dq_o` with `dram_dq_oe` high while the column strobe is low, so the written word can be read back.
- R5: Requests to the row that is already open run as further column accesses without reopening the row, and the column strobe stays high for at least `T_CP` cycles between them.
- R6: The row strobe never stays low for more than `T_RAS_MAX` consecutive cycles. The controller closes the row on its own even while same-row requests keep arriving.
- R7: After the row strobe rises it stays high for at least `T_RP` cycles before it falls again.
- R8: A request to a row other than the open one closes that row, waits out the precharge time and opens the new row, whose address the DRAM latches.
- R9: A refresh burst drops the column strobe while the row strobe is high. It then gives exactly `REF_PULSES` row-strobe pulses with the column strobe held low throughout and write-enable high.
- R10: Refresh bursts start at the rate `REF_BURST_HZ` derived from `CLK_HZ`. A pending refresh blocks new host requests (`req_ready` low), so the gap between burst starts never exceeds the period by more than one access plus precharge.
- R11: Every accepted read produces exactly one `rd_valid` pulse, in the order the reads were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits, column in the lower bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_o | output | DATA_W | Data towards the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_i | input | DATA_W | Data from the DRAM |

## Verification
The bench runs a behavioural DRAM that latches row and column on the strobe edges and keeps its own store, so a controller that puts the wrong half of the address on the bus, or samples read data too early, returns words that do not match the scoreboard. Long runs of same-row reads are aimed at the row-strobe limit: a design that never closes the open row would hold the strobe low indefinitely and open only one row. Row-miss sequences catch a controller that reuses the stale row, or that reopens without precharge. Refresh bursts are counted pulse by pulse while traffic is heavy, which exposes a burst that is one pulse short, a column strobe released mid-burst, or a refresh starved by host requests.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

  typedef enum logic [3:0] {
    S_IDLE,    // row closed, precharged
    S_ROWADR,  // row address on bus, strobe still high
    S_RCD,     // row strobe low, waiting before first column
    S_ACTIVE,  // row open, waiting for next request
    S_COLSET,  // column address / write enable set up
    S_CASLO,   // column strobe low
    S_CASPRE,  // column strobe high between accesses
    S_PRECH,   // row strobe high, precharge
    S_REFCAS,  // column strobe low ahead of refresh pulses
    S_REFRAS,  // refresh pulse, row strobe low
    S_REFRP    // refresh pulse precharge
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dctl_refresh_timer.sv
module dctl_refresh_timer #(
  parameter int PERIOD = 3125
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int TW = $clog2(PERIOD + 1);

  logic [TW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == TW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      pend  <= tick | (pend & ~ack);
    end
  end

  // a request stays raised until the sequencer takes it
  p_pend_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);

  p_tick_raises_r10: assert property (@(posedge clk) disable iff (rst)
    tick |=> pend);

endmodule

// File: rtl/dctl_ras_budget.sv
module dctl_ras_budget #(
  parameter int T_RAS_MAX = 24,
  parameter int COL_LEN   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  output logic room
);
  localparam int CW = $clog2(T_RAS_MAX + 2) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || ras_n) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // one more column access plus the closing cycle must fit in the limit
  assign room = (int'(cnt_q) + COL_LEN + 2) <= T_RAS_MAX;

endmodule

// File: rtl/dctl_sequencer.sv
module dctl_sequencer
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W      = 9,
  parameter int COL_W      = 8,
  parameter int DATA_W     = 8,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_CP       = 1,
  parameter int T_RP       = 3,
  parameter int T_RASR     = 2,
  parameter int REF_PULSES = 32
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_we,
  input  logic [ROW_W+COL_W-1:0]                 req_addr,
  input  logic [DATA_W-1:0]                      req_wdata,
  output logic                                   rd_valid,
  output logic [DATA_W-1:0]                      rd_data,
  input  logic                                   ref_pend,
  output logic                                   ref_ack,
  input  logic                                   room,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]   dram_addr,
  output logic                                   dram_ras_n,
  output logic                                   dram_cas_n,
  output logic                                   dram_we_n,
  output logic [DATA_W-1:0]                      dram_dq_o,
  output logic                                   dram_dq_oe,
  input  logic [DATA_W-1:0]                      dram_dq_i
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MA_W   = imax(ROW_W, COL_W);
  localparam int TMAX   = imax(imax(imax(T_RCD, T_CAS), imax(T_CP, T_RP)), T_RASR);
  localparam int DLY_W  = $clog2(TMAX + 1);
  localparam int PUL_W  = $clog2(REF_PULSES + 1);

  seq_state_e        state_q, state_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [PUL_W-1:0]  pul_q, pul_d;
  logic [ADDR_W-1:0] hadr_q, hadr_d;
  logic              hwe_q, hwe_d;
  logic [DATA_W-1:0] hwd_q, hwd_d;
  logic              pend_q, pend_d;
  logic [ROW_W-1:0]  orow_q, orow_d;
  logic [ROW_W-1:0]  req_row;
  logic              done;
  logic              rd_take;

  assign done      = (dly_q == '0);
  assign req_row   = req_addr[ADDR_W-1:COL_W];
  assign req_ready = !ref_pend &&
                     ((state_q == S_IDLE) || ((state_q == S_ACTIVE) && room));
  assign rd_take   = (state_q == S_CASLO) && done && !hwe_q;

  always_comb begin
    state_d = state_q;
    dly_d   = done ? dly_q : dly_q - 1'b1;
    pul_d   = pul_q;
    hadr_d  = hadr_q;
    hwe_d   = hwe_q;
    hwd_d   = hwd_q;
    pend_d  = pend_q;
    orow_d  = orow_q;
    ref_ack = 1'b0;

    if (req_valid && req_ready) begin
      hadr_d = req_addr;
      hwe_d  = req_we;
      hwd_d  = req_wdata;
    end

    unique case (state_q)
      S_IDLE: begin
        if (ref_pend) begin
          state_d = S_REFCAS;
          ref_ack = 1'b1;
        end else if (req_valid) begin
          state_d = S_ROWADR;
        end
      end
      S_ACTIVE: begin
        if (ref_pend || !room) begin
          state_d = S_PRECH;
          dly_d   = DLY_W'(T_RP - 1);
        end else if (req_valid) begin
          if (req_row == orow_q) begin
            state_d = S_COLSET;
          end else begin
            state_d = S_PRECH;
            dly_d   = DLY_W'(T_RP - 1);
            pend_d  = 1'b1;
          end
        end
      end
      S_ROWADR: begin
        state_d = S_RCD;
        dly_d   = DLY_W'(T_RCD - 1);
        orow_d  = hadr_q[ADDR_W-1:COL_W];
      end
      S_RCD: begin
        if (done) begin
          state_d = S_COLSET;
          pend_d  = 1'b0;
        end
      end
      S_COLSET: begin
        state_d = S_CASLO;
        dly_d   = DLY_W'(T_CAS - 1);
      end
      S_CASLO: begin
        if (done) begin
          state_d = S_CASPRE;
          dly_d   = DLY_W'(T_CP - 1);
        end
      end
      S_CASPRE: begin
        if (done) state_d = S_ACTIVE;
      end
      S_PRECH: begin
        if (done) begin
          if (ref_pend) begin
            state_d = S_REFCAS;
            ref_ack = 1'b1;
          end else if (pend_q) begin
            state_d = S_ROWADR;
          end else begin
            state_d = S_IDLE;
          end
        end
      end
      S_REFCAS: begin
        state_d = S_REFRAS;
        dly_d   = DLY_W'(T_RASR - 1);
        pul_d   = '0;
      end
      S_REFRAS: begin
        if (done) begin
          state_d = S_REFRP;
          dly_d   = DLY_W'(T_RP - 1);
        end
      end
      S_REFRP: begin
        if (done) begin
          if (pul_q == PUL_W'(REF_PULSES - 1)) begin
            state_d = pend_q ? S_ROWADR : S_IDLE;
          end else begin
            pul_d   = pul_q + 1'b1;
            state_d = S_REFRAS;
            dly_d   = DLY_W'(T_RASR - 1);
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      dly_q   <= '0;
      pul_q   <= '0;
      hadr_q  <= '0;
      hwe_q   <= 1'b0;
      hwd_q   <= '0;
      pend_q  <= 1'b0;
      orow_q  <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
      pul_q   <= pul_d;
      hadr_q  <= hadr_d;
      hwe_q   <= hwe_d;
      hwd_q   <= hwd_d;
      pend_q  <= pend_d;
      orow_q  <= orow_d;
    end
  end

  // registered pin drivers, decoded from the state being entered
  always_ff @(posedge clk) begin
    if (rst) begin
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_dq_oe <= 1'b0;
      dram_dq_o  <= '0;
      dram_addr  <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      dram_ras_n <= !(state_d inside {S_RCD, S_ACTIVE, S_COLSET, S_CASLO,
                                      S_CASPRE, S_REFRAS});
      dram_cas_n <= !(state_d inside {S_CASLO, S_REFCAS, S_REFRAS, S_REFRP});
      dram_we_n  <= !((state_d inside {S_COLSET, S_CASLO}) && hwe_d);
      dram_dq_oe <= (state_d inside {S_COLSET, S_CASLO}) && hwe_d;
      dram_dq_o  <= hwd_d;
      unique case (state_d)
        S_ROWADR, S_RCD:            dram_addr <= MA_W'(hadr_d[ADDR_W-1:COL_W]);
        S_COLSET, S_CASLO:          dram_addr <= MA_W'(hadr_d[COL_W-1:0]);
        S_REFCAS, S_REFRAS, S_REFRP: dram_addr <= '0;
        default:                    dram_addr <= dram_addr;
      endcase
      rd_valid <= rd_take;
      if (rd_take) rd_data <= dram_dq_i;
    end
  end

  // data is only driven during a write column cycle
  p_oe_with_we_r4: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> !dram_we_n);

  // a column access only happens inside an open row
  p_col_in_row_r3: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && !dram_we_n) |-> !dram_ras_n);

endmodule

// File: rtl/dram_ctl.sv
module dram_ctl #(
  parameter int ROW_W        = 9,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 8,
  parameter int CLK_HZ       = 50_000_000,
  parameter int REF_BURST_HZ = 16_000,
  parameter int REF_PULSES   = 32,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 1,
  parameter int T_RP         = 3,
  parameter int T_RASR       = 2,
  parameter int T_RAS_MAX    = 24
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic                                 req_we,
  input  logic [ROW_W+COL_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]                    req_wdata,
  output logic                                 rd_valid,
  output logic [DATA_W-1:0]                    rd_data,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0] dram_addr,
  output logic                                 dram_ras_n,
  output logic                                 dram_cas_n,
  output logic                                 dram_we_n,
  output logic [DATA_W-1:0]                    dram_dq_o,
  output logic                                 dram_dq_oe,
  input  logic [DATA_W-1:0]                    dram_dq_i
);
  localparam int REF_PERIOD = CLK_HZ / REF_BURST_HZ;
  localparam int COL_LEN    = 1 + T_CAS + T_CP;

  logic ref_pend;
  logic ref_ack;
  logic room;

  dctl_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .ack  (ref_ack),
    .pend (ref_pend)
  );

  dctl_ras_budget #(.T_RAS_MAX(T_RAS_MAX), .COL_LEN(COL_LEN)) u_budget (
    .clk   (clk),
    .rst   (rst),
    .ras_n (dram_ras_n),
    .room  (room)
  );

  dctl_sequencer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
    .T_RASR(T_RASR), .REF_PULSES(REF_PULSES)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .ref_pend   (ref_pend),
    .ref_ack    (ref_ack),
    .room       (room),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_dq_o  (dram_dq_o),
    .dram_dq_oe (dram_dq_oe),
    .dram_dq_i  (dram_dq_i)
  );

  // independent run-length counters on the strobe pin
  int unsigned chk_lo, chk_hi;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_lo <= 0;
      chk_hi <= T_RP;
    end else begin
      chk_lo <= dram_ras_n ? 0 : chk_lo + 1;
      chk_hi <= dram_ras_n ? chk_hi + 1 : 0;
    end
  end

  p_ras_max_r6: assert property (@(posedge clk) disable iff (rst)
    !dram_ras_n |-> (chk_lo < T_RAS_MAX));

  p_precharge_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (chk_hi >= T_RP));

  p_row_addr_held_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> $stable(dram_addr));

  p_cas_steady_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> $stable(dram_cas_n));

  p_we_lead_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0));

  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_refresh_first_r10: assert property (@(posedge clk) disable iff (rst)
    ref_pend |-> !req_ready);

endmodule

// File: tb/sim_dram_ctl.sv
module sim_dram_ctl;
  localparam int CLK_PERIOD   = 10;
  localparam int ROW_W        = 9;
  localparam int COL_W        = 8;
  localparam int DATA_W       = 8;
  localparam int ADDR_W       = ROW_W + COL_W;
  localparam int MA_W         = 9;
  localparam int CLK_HZ       = 50_000_000;
  localparam int REF_BURST_HZ = 16_000;
  localparam int REF_PERIOD   = CLK_HZ / REF_BURST_HZ;
  localparam int REF_PULSES   = 32;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3, T_RASR = 2, T_RAS_MAX = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DATA_W-1:0] rd_data, dram_dq_o;
  logic [DATA_W-1:0] dram_dq_i = '0;
  logic [MA_W-1:0] dram_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_ctl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CLK_HZ(CLK_HZ),
    .REF_BURST_HZ(REF_BURST_HZ), .REF_PULSES(REF_PULSES), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RASR(T_RASR), .T_RAS_MAX(T_RAS_MAX)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural DRAM and pin monitor ----------------
  logic [DATA_W-1:0] mem_m [int];
  logic [DATA_W-1:0] mem_x [int];
  logic [DATA_W-1:0] expq [$];
  logic [ROW_W-1:0] row_l = '0;
  logic [COL_W-1:0] col_l = '0;
  bit p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, in_burst = 1'b0;
  int cyc = 0, lo_run = 0, hi_run = 100, cas_hi = 100, max_lo = 0, opens = 0;
  int rcd_bad = 0, we_bad = 0, oe_bad = 0, cp_bad = 0, rp_bad = 0;
  int bursts = 0, burst_pul = 0, burst_bad = 0, ref_we_bad = 0, last_bs = -1, max_gap = 0;

  function automatic logic [DATA_W-1:0] rd_m(input int k);
    return mem_m.exists(k) ? mem_m[k] : '0;
  endfunction

  function automatic logic [DATA_W-1:0] rd_x(input int k);
    return mem_x.exists(k) ? mem_x[k] : '0;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (p_ras && !dram_ras_n) begin
        if (hi_run < T_RP) rp_bad++;
        lo_run = 0;
        if (!dram_cas_n) begin
          if (in_burst) burst_pul++;
        end else begin
          row_l = dram_addr[ROW_W-1:0];
          opens++;
        end
      end
      if (!p_ras && dram_ras_n) hi_run = 0;
      if (p_cas && !dram_cas_n) begin
        if (dram_ras_n) begin
          in_burst = 1'b1;
          burst_pul = 0;
          bursts++;
          if (last_bs >= 0 && (cyc - last_bs) > max_gap) max_gap = cyc - last_bs;
          last_bs = cyc;
        end else begin
          col_l = dram_addr[COL_W-1:0];
          if (lo_run < T_RCD) rcd_bad++;
          if (cas_hi < T_CP) cp_bad++;
          if (!dram_we_n) begin
            if (p_we) we_bad++;
            if (!dram_dq_oe) oe_bad++;
            mem_m[int'({row_l, col_l})] = dram_dq_o;
          end
        end
      end
      if (!p_cas && dram_cas_n) begin
        cas_hi = 0;
        if (in_burst) begin
          in_burst = 1'b0;
          if (burst_pul != REF_PULSES) burst_bad++;
        end
      end
      if (in_burst && !dram_we_n) ref_we_bad++;
      if (!dram_ras_n && !dram_cas_n && dram_we_n) dram_dq_i = rd_m(int'({row_l, col_l}));
      else dram_dq_i = '0;
      if (!dram_ras_n) begin
        lo_run++;
        if (lo_run > max_lo) max_lo = lo_run;
      end else begin
        hi_run++;
      end
      if (dram_cas_n) cas_hi++;
      p_ras = dram_ras_n;
      p_cas = dram_cas_n;
      p_we  = dram_we_n;
    end
  end

  // read return monitor (R3, R11)
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R11 unexpected rd_valid", 1, 0);
      end else begin
        logic [DATA_W-1:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R3 read data", int'(rd_data), int'(e));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit we, input int row, input int col, input logic [DATA_W-1:0] d);
    logic [ADDR_W-1:0] a;
    a = {ROW_W'(row), COL_W'(col)};
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (we) mem_x[int'(a)] = d;
    else expq.push_back(rd_x(int'(a)));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (T_RAS_MAX + 12) @(negedge clk);
  endtask

  initial begin
    int o0;
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk({dram_ras_n, dram_cas_n, dram_we_n, req_ready, dram_dq_oe, rd_valid} == 6'b111100,
        "R1 pins after reset",
        int'({dram_ras_n, dram_cas_n, dram_we_n, req_ready, dram_dq_oe, rd_valid}), 6'b111100);

    // R4 and R3: write then read back
    issue(1'b1, 5, 3, 8'hA5);
    issue(1'b0, 5, 3, 8'h00);
    settle();
    chk({dram_ras_n, dram_cas_n, dram_we_n, req_ready} == 4'b1111, "R1 idle after traffic",
        int'({dram_ras_n, dram_cas_n, dram_we_n, req_ready}), 4'b1111);

    // R5: three same-row accesses, one row open
    o0 = opens;
    issue(1'b1, 2, 1, 8'h11);
    issue(1'b1, 2, 2, 8'h22);
    issue(1'b0, 2, 1, 8'h00);
    settle();
    chk(opens - o0 == 1, "R5 row hit opens", opens - o0, 1);

    // R8: row miss
    o0 = opens;
    issue(1'b0, 2, 2, 8'h00);
    issue(1'b0, 7, 0, 8'h00);
    settle();
    chk(opens - o0 == 2, "R8 row miss opens", opens - o0, 2);
    chk(int'(row_l) == 7, "R8 latched row", int'(row_l), 7);

    // R6: long same-row stream forces a close
    o0 = opens;
    for (int i = 0; i < 12; i++) issue(1'b0, 3, i, 8'h00);
    settle();
    chk(opens - o0 >= 2, "R6 forced close", opens - o0, 2);

    // random traffic over a few rows
    for (int i = 0; i < 800; i++) begin
      issue(1'($urandom % 2), int'($urandom % 4), int'($urandom % 16), 8'($urandom));
      if ($urandom % 8 == 0) repeat ($urandom % 30) @(negedge clk);
    end
    while (cyc < 2 * REF_PERIOD + 400) @(negedge clk);
    repeat (60) @(negedge clk);

    chk(max_lo <= T_RAS_MAX, "R6 longest row strobe low", max_lo, T_RAS_MAX);
    chk(rcd_bad == 0, "R2 row-to-column delay", rcd_bad, 0);
    chk(we_bad == 0, "R4 write enable before column strobe", we_bad, 0);
    chk(oe_bad == 0, "R4 data enable during write", oe_bad, 0);
    chk(cp_bad == 0, "R5 column precharge", cp_bad, 0);
    chk(rp_bad == 0, "R7 row precharge", rp_bad, 0);
    chk(burst_bad == 0, "R9 pulses per burst", burst_bad, 0);
    chk(ref_we_bad == 0, "R9 write enable high in refresh", ref_we_bad, 0);
    chk(bursts >= 2 && bursts >= cyc / REF_PERIOD - 1, "R10 burst count", bursts, cyc / REF_PERIOD);
    chk(max_gap <= REF_PERIOD + 64, "R10 burst spacing", max_gap, REF_PERIOD + 64);
    chk(expq.size() == 0, "R11 reads outstanding", expq.size(), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule